// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Timer

This block is one timer channel. It counts down at a programmable tick rate and drives a PWM output and a periodic interrupt. The tick comes from the system clock. An 8-bit prescaler runs first, and a selectable divide-by-2/4/8/16 stage follows it. Both stages produce a one-cycle enable, so no derived clock is created.

Software writes two staging registers, one for the count and one for the compare value. These values reach the running counter and the live compare register only at two times: while software holds the manual-update bit, or on an auto-reload at the end of a period. This lets software prepare the next period while the current one runs. The PWM level inverts when the count passes the compare value and again at the end of each period. One period lasts the staged count plus one ticks.

Everything is reached through a plain synchronous register port. Writes are strobed by `wrEn`, and reads are combinational on `addr`. Register map:

- address 0: control. Bit 0 is start, bit 1 is manual update, bit 2 is auto-reload, bit 3 is interrupt enable.
- address 1: clock setup. Bits [7:0] hold the prescale value P, and bits [9:8] hold the divider select.
- address 2: count staging.
- address 3: compare staging.
- address 4: live count, read-only.
- address 5: status. Bit 0 is the interrupt flag.

Top module: `pwm_timer`

## Requirements
- R1: While start is set, ticks occur every (P+1)*D system clock cycles. The first tick falls (P+1)*D cycles after the clock edge that writes start to 1.
- R2: The divider select in address 1 bits [9:8] picks D: 0 gives 2, 1 gives 4, 2 gives 8 and 3 gives 16.
- R3: Writes to the staging registers leave the live count unchanged. While the manual-update bit is 1, both staging values are copied into the live registers every cycle and no counting happens.
- R4: On each tick while the count is nonzero, the live count, readable at address 4, decreases by one.
- R5: On a tick where the live count is nonzero and equals the live compare value, pwmOut inverts and counting continues.
- R6: On a tick where the live count is 0, pwmOut inverts and the status flag is set. irqOut equals the status flag ANDed with the interrupt-enable bit.
- R7: With auto-reload set, the zero tick reloads both live registers from staging. The count sequence therefore repeats every N+1 ticks, where N is the staged count.
- R8: With auto-reload clear, the channel stops after its zero tick. The count holds at 0, and there are no further toggles or flag sets until a manual update.
- R9: Clearing start freezes the live count and pwmOut at their current values.
- R10: Writing 1 to status bit 0 clears the flag, and writing 0 has no effect. If a zero tick and a clear happen in the same cycle, the set wins.
- R11: After reset, all registers read 0, and pwmOut and irqOut are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data, combinational on addr |
| pwmOut | output | 1 | PWM output level |
| irqOut | output | 1 | Interrupt request |

## Verification
A register write lands on the clock edge inside the write cycle, and a read is combinational in the same cycle. The bench therefore samples reads half a cycle after the last write, with no edge in between.

Tick k after the start edge moves the count on the edge k*(P+1)*D cycles later. The bench waits exactly that many edges and compares the count, PWM parity, flag and interrupt against closed-form functions of N, the compare value, k and the auto-reload bit. When an exact tick phase is unknowable, as after a stop, the bench instead compares values read before and after a quiet window.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_CLK  = 3'd1;
  localparam logic [2:0] ADDR_CNTB = 3'd2;
  localparam logic [2:0] ADDR_CMPB = 3'd3;
  localparam logic [2:0] ADDR_LIVE = 3'd4;
  localparam logic [2:0] ADDR_STAT = 3'd5;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic load;     // copy staging into live registers
    logic dec;      // count down by one
    logic toggle;   // invert the output level
    logic setFlag;  // end-of-period event
  } dpStrobes_t;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int PRE_W = 8,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic [PRE_W-1:0] preVal,
  input  logic [DIV_W-1:0] divSel,
  output logic             tick
);
  localparam int DCNT_W = 1 << DIV_W;

  logic [PRE_W-1:0]  preCnt;
  logic [DCNT_W-1:0] divCnt;
  logic [DIV_W-1:0]  selHeld;
  logic [DCNT_W-1:0] ratioM1;
  logic              preWrap;

  // ratio 2^(sel+1) minus one: ones in bits 0..sel
  always_comb begin
    ratioM1 = '0;
    for (int i = 0; i < DCNT_W; i++)
      if (i <= int'(selHeld)) ratioM1[i] = 1'b1;
  end

  assign preWrap = en && (preCnt >= preVal);
  assign tick    = preWrap && (divCnt >= ratioM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      divCnt  <= '0;
      selHeld <= '0;
    end else if (!en) begin
      preCnt  <= '0;
      divCnt  <= '0;
      selHeld <= divSel;
    end else if (preWrap) begin
      preCnt  <= '0;
      selHeld <= divSel;
      divCnt  <= (divCnt >= ratioM1) ? '0 : divCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       stb,
  input  logic [CNT_W-1:0] cntBuf,
  input  logic [CNT_W-1:0] cmpBuf,
  output logic [CNT_W-1:0] liveCnt,
  output logic             cntZero,
  output logic             cntAtCmp,
  output logic             pwmOut
);
  logic [CNT_W-1:0] liveCmp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveCnt <= '0;
      liveCmp <= '0;
      pwmOut  <= 1'b0;
    end else begin
      if (stb.load) begin
        liveCnt <= cntBuf;
        liveCmp <= cmpBuf;
      end else if (stb.dec) begin
        liveCnt <= liveCnt - 1'b1;
      end
      if (stb.toggle) pwmOut <= ~pwmOut;
    end
  end

  assign cntZero  = (liveCnt == '0);
  assign cntAtCmp = (liveCnt == liveCmp);

  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.dec |=> liveCnt == CNT_W'($past(liveCnt) - 1'b1));
  // R3
  load_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> liveCnt == $past(cntBuf));
  // R5
  pwm_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.toggle |=> $stable(pwmOut));
endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int DIV_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              tick,
  input  logic [CNT_W-1:0]  liveCnt,
  input  logic              cntZero,
  input  logic              cntAtCmp,
  output dpStrobes_t        stb,
  output logic              runEn,
  output logic [PRE_W-1:0]  preVal,
  output logic [DIV_W-1:0]  divSel,
  output logic [CNT_W-1:0]  cntBuf,
  output logic [CNT_W-1:0]  cmpBuf,
  output logic              irqOut
);
  logic startBit, manualBit, autoReload, irqEn, statFlag, halted;
  logic clrFlag;

  assign clrFlag = wrEn && (addr == ADDR_STAT) && wrData[0];

  always_comb begin
    stb = '0;
    if (manualBit) begin
      stb.load = 1'b1;
    end else if (startBit && tick && !halted) begin
      if (cntZero) begin
        stb.toggle  = 1'b1;
        stb.setFlag = 1'b1;
        stb.load    = autoReload;
      end else begin
        stb.dec    = 1'b1;
        stb.toggle = cntAtCmp;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {irqEn, autoReload, manualBit, startBit} <= '0;
      preVal   <= '0;
      divSel   <= '0;
      cntBuf   <= '0;
      cmpBuf   <= '0;
      statFlag <= 1'b0;
      halted   <= 1'b0;
    end else begin
      if (wrEn) begin
        case (addr)
          ADDR_CTRL: {irqEn, autoReload, manualBit, startBit} <= wrData[3:0];
          ADDR_CLK: begin
            preVal <= wrData[PRE_W-1:0];
            divSel <= wrData[PRE_W +: DIV_W];
          end
          ADDR_CNTB: cntBuf <= wrData[CNT_W-1:0];
          ADDR_CMPB: cmpBuf <= wrData[CNT_W-1:0];
          default: ;
        endcase
      end
      if (stb.setFlag)  statFlag <= 1'b1;
      else if (clrFlag) statFlag <= 1'b0;
      if (manualBit)                          halted <= 1'b0;
      else if (stb.setFlag && !autoReload)    halted <= 1'b1;
    end
  end

  assign runEn  = startBit;
  assign irqOut = statFlag && irqEn;

  always_comb begin
    case (addr)
      ADDR_CTRL: rdData = DATA_W'({irqEn, autoReload, manualBit, startBit});
      ADDR_CLK:  rdData = DATA_W'({divSel, preVal});
      ADDR_CNTB: rdData = DATA_W'(cntBuf);
      ADDR_CMPB: rdData = DATA_W'(cmpBuf);
      ADDR_LIVE: rdData = DATA_W'(liveCnt);
      ADDR_STAT: rdData = DATA_W'(statFlag);
      default:   rdData = '0;
    endcase
  end

  // R6
  flag_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statFlag) |-> $past(tick && cntZero));
  // R9
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!startBit && !manualBit) |=> $stable(liveCnt));
  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrFlag && !tick) |=> !statFlag);
  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !manualBit) |=> $stable(liveCnt));
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              pwmOut,
  output logic              irqOut
);
  localparam int DIV_W = 2;

  dpStrobes_t       stb;
  logic             tick, runEn, cntZero, cntAtCmp;
  logic [PRE_W-1:0] preVal;
  logic [DIV_W-1:0] divSel;
  logic [CNT_W-1:0] cntBuf, cmpBuf, liveCnt;

  pwm_tick_gen #(.PRE_W(PRE_W), .DIV_W(DIV_W)) uTick (
    .clk(clk), .rstN(rstN), .en(runEn), .preVal(preVal),
    .divSel(divSel), .tick(tick));

  pwm_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DIV_W(DIV_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .tick(tick), .liveCnt(liveCnt), .cntZero(cntZero),
    .cntAtCmp(cntAtCmp), .stb(stb), .runEn(runEn), .preVal(preVal),
    .divSel(divSel), .cntBuf(cntBuf), .cmpBuf(cmpBuf), .irqOut(irqOut));

  pwm_datapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .cntBuf(cntBuf), .cmpBuf(cmpBuf),
    .liveCnt(liveCnt), .cntZero(cntZero), .cntAtCmp(cntAtCmp), .pwmOut(pwmOut));
endmodule

// File: tb/tb_pwm_timer.sv
module tb_pwm_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        pwmOut, irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  pwm_timer dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut), .irqOut(irqOut));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int expCnt(int n, int k, bit ar);
    if (ar) return n - (k % (n + 1));
    return (k <= n) ? n - k : 0;
  endfunction

  function automatic int expToggles(int n, int cmp, int k, bit ar);
    bit cmpOk = (cmp >= 1) && (cmp <= n);
    int hit = n - cmp + 1;
    if (ar) return (k / (n + 1)) * (cmpOk ? 2 : 1) + ((cmpOk && (k % (n + 1)) >= hit) ? 1 : 0);
    return ((cmpOk && k >= hit) ? 1 : 0) + ((k >= n + 1) ? 1 : 0);
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeReg(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(logic [2:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdData);
  endtask

  // set up, load by manual update, start, wait k ticks, check
  task automatic runCase(int p, int sel, int n, int cmp, int k, bit ar);
    int v, f;
    bit pwm0;
    writeReg(3'd0, 32'd0);
    writeReg(3'd5, 32'd1);
    writeReg(3'd1, (sel << 8) | p);
    writeReg(3'd2, n);
    writeReg(3'd3, cmp);
    writeReg(3'd0, 32'h2 | (ar << 2) | 32'h8);
    writeReg(3'd0, (ar << 2) | 32'h8);
    pwm0 = pwmOut;
    readReg(3'd4, v);
    check("R3 manual load", v, n);
    writeReg(3'd0, 32'h1 | (ar << 2) | 32'h8);
    repeat (k * (p + 1) * (2 << sel)) @(negedge clk);
    readReg(3'd4, v);
    check(ar ? "R1/R2/R4/R7 count" : "R1/R2/R4/R8 count", v, expCnt(n, k, ar));
    check("R5/R6 pwm level", int'(pwmOut), int'(pwm0 ^ expToggles(n, cmp, k, ar)[0]));
    readReg(3'd5, f);
    check("R6 flag", f, (k >= n + 1) ? 1 : 0);
    check("R6 irq", int'(irqOut), (k >= n + 1) ? 1 : 0);
  endtask

  initial begin
    int v, v2;
    bit pw;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R11 reset state
    for (int a = 0; a < 6; a++) begin
      readReg(a[2:0], v);
      check("R11 reset reg", v, 0);
    end
    check("R11 reset pwm", int'(pwmOut), 0);
    check("R11 reset irq", int'(irqOut), 0);
    rstN = 1'b1;

    // directed cases
    runCase(0, 0, 5, 2, 6, 1'b1);
    runCase(1, 1, 3, 0, 9, 1'b1);
    runCase(0, 0, 0, 0, 3, 1'b1);
    runCase(2, 3, 4, 2, 5, 1'b0);
    runCase(0, 2, 4, 2, 12, 1'b0);
    runCase(0, 0, 3, 3, 1, 1'b1);
    runCase(0, 0, 3, 3, 0, 1'b1);

    // R3: staging writes do not reach the live count
    writeReg(3'd0, 32'd0);
    readReg(3'd4, v);
    writeReg(3'd2, 32'd99);
    readReg(3'd4, v2);
    check("R3 staging isolated", v2, v);
    // R3: manual held with start set copies and blocks counting
    writeReg(3'd0, 32'h3);
    repeat (40) @(negedge clk);
    readReg(3'd4, v);
    check("R3 manual held", v, 99);

    // R9: stop freezes count and pwm
    runCase(0, 0, 20, 10, 4, 1'b1);
    writeReg(3'd0, 32'h4);
    readReg(3'd4, v);
    pw = pwmOut;
    repeat (50) @(negedge clk);
    readReg(3'd4, v2);
    check("R9 count frozen", v2, v);
    check("R9 pwm frozen", int'(pwmOut), int'(pw));

    // R10 and R6 enable gating
    runCase(0, 0, 2, 1, 3, 1'b1);
    writeReg(3'd0, 32'h4);
    check("R6 irq masked", int'(irqOut), 0);
    writeReg(3'd5, 32'd0);
    readReg(3'd5, v);
    check("R10 write 0 keeps flag", v, 1);
    writeReg(3'd5, 32'd1);
    readReg(3'd5, v);
    check("R10 write 1 clears", v, 0);

    // R8: one-shot stays stopped
    runCase(0, 0, 3, 1, 10, 1'b0);
    writeReg(3'd5, 32'd1);
    pw = pwmOut;
    repeat (40) @(negedge clk);
    readReg(3'd5, v);
    check("R8 no new flag", v, 0);
    readReg(3'd4, v);
    check("R8 count held", v, 0);
    check("R8 pwm held", int'(pwmOut), int'(pw));

    // random cases
    for (int i = 0; i < 12; i++) begin
      int p = $urandom_range(0, 3);
      int s = $urandom_range(0, 3);
      int n = $urandom_range(0, 7);
      int c = $urandom_range(0, 8);
      int k = $urandom_range(0, 20);
      bit ar = 1'($urandom_range(0, 1));
      runCase(p, s, n, c, k, ar);
    end

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule